// File: doc/BRIEF.md
# Receive Character Queue with Fill-Level Interrupt

This block holds characters received by a serial port until software reads them. Each character arrives from the line side as a 12-bit word: eight data bits in [7:0], with status bits above them. Bit 10 marks a line break. A break event from the line side stores the word 0x400, which has the break bit set and zero data. Each read strobe from the CPU side removes the oldest word. The word at the head of the queue is always visible on `rd_word`.

The queue holds sixteen words when queueing is switched on. When it is switched off it behaves as a single holding register. Any control write that flips the queueing switch discards the stored contents. The block drives an empty flag, a full flag, a ready signal for the line side, and a receive interrupt request. The interrupt sets when a store brings the fill level up to a programmable threshold. It clears when a read brings the level down to one below that threshold.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, `rx_empty`=1, `rx_full`=0, `rx_irq`=0 and `rx_ready`=1. Queueing starts switched off and the level value starts at 0.
- R2: Words are read back in the order they were stored. `rd_word` shows the oldest stored word, and each `rd_pop` advances to the next one.
- R3: Capacity is 16 when the stored switch value `lcr_fifo_en` is 1, and 1 when it is 0. `rx_ready` is 1 exactly when the fill level is below capacity. A store attempted while `rx_ready`=0 changes nothing.
- R4: `rx_empty` clears on every accepted store. It sets on a read that leaves the level at zero.
- R5: `rx_full` clears on every read. It sets on an accepted store when queueing is off or when the level reaches 16.
- R6: The threshold is 1 when queueing is off. When queueing is on, it is `lvl_value[5:3]` times 4. An accepted store that makes the level equal the threshold sets `rx_irq`. A threshold of 0 never sets it.
- R7: A read that leaves the level at threshold minus one clears `rx_irq`.
- R8: When `rx_break` is 1, the stored word is 0x400, whatever `rx_word` holds.
- R9: A `lcr_wr` whose `lcr_fifo_en` differs from the stored switch value empties the queue and moves the read position to slot 0. The flags and `rx_irq` keep their values. Stores and reads in that cycle are dropped.
- R10: A read of an empty queue leaves the read position and level unchanged, so `rd_word` is unchanged. The flag and interrupt rules of R4, R5 and R7 still apply, with a level of 0.
- R11: When a store and a read occur in the same cycle, the read is applied first and the store second. Acceptance is still decided by the level before the read.
- R12: A level or switch write takes effect for the threshold from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Line side offers `rx_word` for storing |
| rx_word | input | 12 | Received word: data [7:0] plus status bits |
| rx_break | input | 1 | Line break seen; stores 0x400 |
| rd_pop | input | 1 | CPU read of the data word; removes the head |
| lcr_wr | input | 1 | Write strobe for the queueing switch |
| lcr_fifo_en | input | 1 | Switch value written by `lcr_wr` |
| lvl_wr | input | 1 | Write strobe for the level value |
| lvl_value | input | 6 | Level value; bits [5:3] select the threshold |
| rd_word | output | 12 | Word at the head of the queue |
| rx_ready | output | 1 | Another word can be stored |
| rx_empty | output | 1 | Empty flag |
| rx_full | output | 1 | Full flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
All inputs are sampled on a rising edge, and every output is registered or decoded from registers. Each result of a stimulus is therefore due one edge later. The level, the flags, `rx_irq`, `rx_ready` and the new head word on `rd_word` all appear in that cycle. The bench drives inputs on the falling edge, updates its own model of the queue at the same moment, and compares every output at the next falling edge. This places each comparison exactly one rising edge after its stimulus. The R12 rule means a level write and a store in the same cycle use the old threshold, and the model follows that ordering.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int WORD_W = 12;
  localparam int LVL_W  = 6;
  localparam int CMP_W  = 8;
  localparam logic [WORD_W-1:0] BREAK_WORD = 12'h400;

  typedef logic [WORD_W-1:0] rx_word_t;

  // threshold: 1 when queueing is off, level bits [5:3] scaled by 4 otherwise
  function automatic logic [CMP_W-1:0] rxq_thr(input logic en, input logic [LVL_W-1:0] lvl);
    logic [CMP_W-1:0] t;
    t = en ? {3'b000, lvl[5:3], 2'b00} : 8'd1;
    return t;
  endfunction
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lcr_wr,
  input  logic             lcr_fifo_en,
  input  logic             lvl_wr,
  input  logic [LVL_W-1:0] lvl_value,
  output logic             fifo_en,
  output logic [CMP_W-1:0] thr,
  output logic             flush_ev
);
  logic             en_q;
  logic [LVL_W-1:0] lvl_q;

  assign flush_ev = lcr_wr && (lcr_fifo_en != en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (lcr_wr) en_q  <= lcr_fifo_en;
      if (lvl_wr) lvl_q <= lvl_value;
    end
  end

  assign fifo_en = en_q;
  assign thr     = rxq_thr(en_q, lvl_q);

  // R12
  lvl_takes_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> (lvl_q == $past(lvl_value)));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_slot,
  input  rx_word_t         wr_word,
  input  logic [PTR_W-1:0] rd_ptr,
  output rx_word_t         rd_word
);
  rx_word_t cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    rx_word_t cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cell_q <= '0;
      else if (wr_en && (wr_slot == PTR_W'(g)))     cell_q <= wr_word;
    end
    assign cells[g] = cell_q;
  end

  assign rd_word = cells[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             flush_ev,
  input  logic             fifo_en,
  input  logic [CMP_W-1:0] thr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_slot,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             ready,
  output logic             empty,
  output logic             full,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [CMP_W-1:0] CMP_DEPTH = CMP_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_mid;
  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_n;
  logic [CNT_W-1:0] cap;
  logic             empty_q, full_q, irq_q;
  logic             empty_n, full_n, irq_n;
  logic             push_eff, pop_act, pop_move;
  logic [CMP_W-1:0] mid_plus1;

  // slot after the last stored word, wrapping around the ring
  function automatic logic [PTR_W-1:0] ring_slot(input logic [PTR_W-1:0] p, input logic [CNT_W-1:0] c);
    return p + PTR_W'(c);
  endfunction

  assign cap      = fifo_en ? CNT_W'(DEPTH) : CNT_ONE;
  assign ready    = (cnt_q < cap);
  assign push_eff = push_req && ready && !flush_ev;
  assign pop_act  = pop_req && !flush_ev;
  assign pop_move = pop_act && (cnt_q != '0);

  assign ptr_mid   = pop_move ? ptr_q + PTR_ONE : ptr_q;
  assign cnt_mid   = pop_move ? cnt_q - CNT_ONE : cnt_q;
  assign mid_plus1 = CMP_W'(cnt_mid) + CMP_W'(1);
  assign cnt_n     = push_eff ? cnt_mid + CNT_ONE : cnt_mid;

  assign wr_en   = push_eff;
  assign wr_slot = ring_slot(ptr_mid, cnt_mid);

  always_comb begin
    empty_n = empty_q;
    full_n  = full_q;
    irq_n   = irq_q;
    // read applied first
    if (pop_act) begin
      full_n = 1'b0;
      if (cnt_mid == '0)      empty_n = 1'b0 | 1'b1;
      if (mid_plus1 == thr)   irq_n   = 1'b0;
    end
    // then the store
    if (push_eff) begin
      empty_n = 1'b0;
      if (!fifo_en || (mid_plus1 == CMP_DEPTH)) full_n = 1'b1;
      if (mid_plus1 == thr)                     irq_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else if (flush_ev) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q   <= ptr_mid;
      cnt_q   <= cnt_n;
      empty_q <= empty_n;
      full_q  <= full_n;
      irq_q   <= irq_n;
    end
  end

  assign rd_ptr = ptr_q;
  assign empty  = empty_q;
  assign full   = full_q;
  assign irq    = irq_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R3
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !$past(flush_ev)) |-> (cnt_q <= CNT_ONE));
  // R4
  store_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && ready && !flush_ev) |=> !empty);
  // R5
  read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !flush_ev) |=> !full);
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ev |=> (cnt_q == '0 && rd_ptr == '0));
  // R10
  empty_read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && !push_req && !flush_ev) |=> $stable(rd_ptr));
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [11:0] rx_word,
  input  logic        rx_break,
  input  logic        rd_pop,
  input  logic        lcr_wr,
  input  logic        lcr_fifo_en,
  input  logic        lvl_wr,
  input  logic [5:0]  lvl_value,
  output logic [11:0] rd_word,
  output logic        rx_ready,
  output logic        rx_empty,
  output logic        rx_full,
  output logic        rx_irq
);
  logic             fifo_en, flush_ev, push_req, wr_en;
  logic [CMP_W-1:0] thr;
  logic [PTR_W-1:0] wr_slot, rd_ptr;
  rx_word_t         push_word;

  assign push_req  = rx_valid || rx_break;
  assign push_word = rx_break ? BREAK_WORD : rx_word;

  rxq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .lcr_wr(lcr_wr), .lcr_fifo_en(lcr_fifo_en),
    .lvl_wr(lvl_wr), .lvl_value(lvl_value),
    .fifo_en(fifo_en), .thr(thr), .flush_ev(flush_ev)
  );

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(rd_pop),
    .flush_ev(flush_ev), .fifo_en(fifo_en), .thr(thr),
    .wr_en(wr_en), .wr_slot(wr_slot), .rd_ptr(rd_ptr),
    .ready(rx_ready), .empty(rx_empty), .full(rx_full), .irq(rx_irq)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_word(push_word), .rd_ptr(rd_ptr), .rd_word(rd_word)
  );

  // R8
  break_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && wr_en) |-> (push_word == 12'h400));
endmodule

// File: tb/rx_char_queue_bench.sv
module rx_char_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_break = 1'b0, rd_pop = 1'b0;
  logic [11:0] rx_word = '0;
  logic        lcr_wr = 1'b0, lcr_fifo_en = 1'b0, lvl_wr = 1'b0;
  logic [5:0]  lvl_value = '0;
  logic [11:0] rd_word;
  logic        rx_ready, rx_empty, rx_full, rx_irq;

  int errs = 0, checks = 0;
  bit finished = 1'b0;

  // bench model
  logic [11:0] m_mem [16];
  int  m_cnt = 0, m_ptr = 0;
  bit  m_en = 0, m_empty = 1, m_full = 0, m_irq = 0;
  logic [5:0] m_lvl = '0;

  always #2.5 clk = ~clk;

  rx_char_queue u_rx_char_queue (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_break(rx_break), .rd_pop(rd_pop), .lcr_wr(lcr_wr),
    .lcr_fifo_en(lcr_fifo_en), .lvl_wr(lvl_wr), .lvl_value(lvl_value),
    .rd_word(rd_word), .rx_ready(rx_ready), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_irq(rx_irq)
  );

  function automatic int b_thr();
    if (!m_en) return 1;
    return int'(m_lvl / 8) * 4;
  endfunction

  function automatic int b_cap();
    return m_en ? 16 : 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 head word", 32'(rd_word), 32'(m_mem[m_ptr]));
    chk("R3 ready", 32'(rx_ready), 32'(m_cnt < b_cap()));
    chk("R4 empty", 32'(rx_empty), 32'(m_empty));
    chk("R5 full", 32'(rx_full), 32'(m_full));
    chk("R6/R7 irq", 32'(rx_irq), 32'(m_irq));
  endtask

  // drive one cycle at the falling edge, update the model, check at the next falling edge
  task automatic tick(bit v, logic [11:0] w, bit b, bit p, bit lw, bit le, bit vw, logic [5:0] vv);
    int t;
    bit acc;
    rx_valid = v; rx_word = w; rx_break = b; rd_pop = p;
    lcr_wr = lw; lcr_fifo_en = le; lvl_wr = vw; lvl_value = vv;
    t = b_thr();
    if (lw && (le != m_en)) begin
      m_ptr = 0; m_cnt = 0; m_en = le;
    end else begin
      acc = (v || b) && (m_cnt < b_cap());
      if (p) begin
        if (m_cnt > 0) begin m_ptr = (m_ptr + 1) % 16; m_cnt--; end
        m_full = 0;
        if (m_cnt == 0) m_empty = 1;
        if (m_cnt == t - 1) m_irq = 0;
      end
      if (acc) begin
        m_mem[(m_ptr + m_cnt) % 16] = b ? 12'h400 : w;
        m_cnt++;
        m_empty = 0;
        if (!m_en || m_cnt == 16) m_full = 1;
        if (m_cnt == t) m_irq = 1;
      end
    end
    if (vw) m_lvl = vv;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0; rx_break = 0; rd_pop = 0; lcr_wr = 0; lvl_wr = 0;
    check_all();
  endtask

  task automatic push(logic [11:0] w);  tick(1, w, 0, 0, 0, 0, 0, 0); endtask
  task automatic pop();                 tick(0, 0, 0, 1, 0, 0, 0, 0); endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", 32'(rx_empty), 1);
    chk("R1 full", 32'(rx_full), 0);
    chk("R1 irq", 32'(rx_irq), 0);
    chk("R1 ready", 32'(rx_ready), 1);

    // switch queueing on, threshold 8
    tick(0, 0, 0, 0, 1, 1, 1, 6'b010_000);
    for (int i = 0; i < 16; i++) push(12'h0A0 + 12'(i));
    chk("R5 full at 16", 32'(rx_full), 1);
    chk("R3 not ready at 16", 32'(rx_ready), 0);
    push(12'hBAD);
    chk("R3 ignored store", 32'(rd_word), 32'h0A0);
    for (int i = 0; i < 16; i++) begin
      chk("R2 order", 32'(rd_word), 32'h0A0 + 32'(i));
      pop();
    end
    chk("R7 irq cleared", 32'(rx_irq), 0);
    chk("R4 empty after drain", 32'(rx_empty), 1);
    pop();
    chk("R10 empty read holds word", 32'(rd_word), 32'(m_mem[m_ptr]));

    // R8 break overrides data
    tick(1, 12'h0FF, 1, 0, 0, 0, 0, 0);
    chk("R8 break word", 32'(rd_word), 32'h400);
    // R11 store and read together
    push(12'h011);
    tick(1, 12'h022, 0, 1, 0, 0, 0, 0);
    chk("R11 read then store head", 32'(rd_word), 32'h011);

    // R9 switch off: contents dropped, flags kept
    tick(1, 12'h033, 0, 0, 1, 0, 0, 0);
    chk("R9 ready after flush", 32'(rx_ready), 1);
    chk("R9 empty flag kept", 32'(rx_empty), 0);
    push(12'h044);
    chk("R3 single slot full", 32'(rx_ready), 0);
    chk("R6 irq at threshold 1", 32'(rx_irq), 1);

    // R12 level write and store in same cycle use old threshold
    tick(0, 0, 0, 0, 1, 1, 0, 0);
    tick(1, 12'h055, 0, 0, 0, 0, 1, 6'b001_000);
    tick(1, 12'h066, 0, 0, 0, 0, 0, 0);
    tick(1, 12'h077, 0, 0, 0, 0, 0, 0);
    tick(1, 12'h088, 0, 0, 0, 0, 0, 0);
    chk("R12 irq with new threshold 4", 32'(rx_irq), 32'(m_irq));

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      bit v, b, p, lw, le, vw;
      v  = ($urandom % 100) < 50;
      b  = ($urandom % 100) < 4;
      p  = ($urandom % 100) < 42;
      lw = ($urandom % 100) < 3;
      le = ($urandom % 100) < 80;
      vw = ($urandom % 100) < 5;
      tick(v, 12'($urandom), b, p, lw, le, vw, 6'($urandom));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule